// File: doc/BRIEF.md
# Event Ring Producer with Completion Interrupt

This block is the device-side writer for a circular event ring that lives in host memory. Three internal sources raise event requests: state-change notices, command completions and transfer completions. The block takes one request at a time and builds a small descriptor from a kind field and a source-supplied code. It writes that descriptor to the slot its own read pointer selects, through a simple valid/acknowledge memory-write port. Once the write is acknowledged, it advances the pointer and pulses an interrupt toward the host.

The pointer roles are the reverse of a conventional queue. The device produces at the read pointer. The host hands slots back by writing a new value of the write pointer. The ring counts as full, and nothing further may be produced, when the read pointer equals the host's write pointer. It holds no unserviced events when the write pointer plus one equals the read pointer. From reset the read pointer is 0 and the write pointer is RING_DEPTH-1, so RING_DEPTH-1 events can be written before the host returns any space.

Top module: `event_ring_producer`

## Requirements
- R1: After reset, mw_valid, irq and every src_ready bit are low, and the first descriptor written goes to slot 0, at address BASE_ADDR.
- R2: At most one src_ready bit is high in any cycle. A request is taken on a clock edge where its src_valid and src_ready are both high.
- R3: A taken request produces mw_data = {kind[1:0], code[CODE_W-1:0]}. The kind is the source index: 0 for a state change, 1 for a command completion, 2 for a transfer completion. The code is that source's slice src_code[i*CODE_W +: CODE_W]. The write goes to mw_addr = BASE_ADDR + slot*ELEM_BYTES.
- R4: Once mw_valid rises, it stays high with mw_addr and mw_data unchanged until the edge where mw_ack is sampled high.
- R5: Each acknowledged write moves the read pointer up by one slot, wrapping from RING_DEPTH-1 to 0.
- R6: While the read pointer equals the host write pointer, no request is taken and no write is started.
- R7: A write on host_wp_we loads host_wp as the host write pointer. After that, exactly (host_wp - read pointer) mod RING_DEPTH further events are accepted before the ring is full again.
- R8: irq is high for exactly the one cycle after each acknowledged write, and is low at every other time.
- R9: When several sources request in the same cycle, state change wins over command completion, which wins over transfer completion.
- R10: All src_ready bits stay low while a memory write is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 3 | Request per source (0 state change, 1 command, 2 transfer) |
| src_code | input | 3*CODE_W | Per-source event code, source i in bits [i*CODE_W +: CODE_W] |
| src_ready | output | 3 | Per-source acceptance |
| host_wp_we | input | 1 | Host write-pointer update strobe |
| host_wp | input | $clog2(RING_DEPTH) | New host write pointer |
| mw_valid | output | 1 | Memory write request |
| mw_addr | output | ADDR_W | Byte address of the descriptor slot |
| mw_data | output | 2+CODE_W | Descriptor: kind and code |
| mw_ack | input | 1 | Memory write acknowledge |
| irq | output | 1 | One-cycle interrupt pulse after each completed write |

## Verification
The bench targets the swapped full test. It fills the ring from reset and holds a request against a full ring. A design that used the conventional empty/full relation would either overwrite an unserviced slot or refuse service much too early. The bench then returns a few slots through a host pointer write and counts exactly how many events get through. A design that miscounted free space would take one event too many or too few. The bench drives the pointer across the wrap, where a missing modulo would send a descriptor past the ring. It also raises simultaneous requests, where a reversed priority would write the transfer event first. It holds a request during a slow acknowledge, where a design that dropped its busy gating would take a second event before the first was written.

// File: rtl/evr_pkg.sv
package evr_pkg;
   localparam int EVR_NSRC   = 3;
   localparam int EVR_KIND_W = 2;

   // Kind code equals the source index; lower index has higher priority.
   typedef enum logic [EVR_KIND_W-1:0] {
      KIND_STATE = 2'd0,
      KIND_CMD   = 2'd1,
      KIND_XFER  = 2'd2
   } evr_kind_e;

   typedef enum logic {
      PH_IDLE,
      PH_WRITE
   } evr_phase_e;
endpackage

// File: rtl/evr_prio_pick.sv
module evr_prio_pick #(
   parameter int N     = 3,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   output logic [N-1:0]     grant,
   output logic [IDX_W-1:0] idx
);
   initial assert (N >= 2) else $error("evr_prio_pick: N must be at least 2");

   for (genvar i = 0; i < N; i++) begin : g_grant
      if (i == 0) begin : g_top
         assign grant[i] = req[i];
      end else begin : g_rest
         assign grant[i] = req[i] & ~(|req[i-1:0]);
      end
   end

   always_comb begin
      idx = '0;
      for (int k = N-1; k >= 0; k--) begin
         if (grant[k]) idx = IDX_W'(k);
      end
   end

   // R9
   top_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req[0] |-> (grant == N'(1)));
   // R2
   single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((|req) == (|grant)));
endmodule

// File: rtl/evr_ring_ptr.sv
module evr_ring_ptr #(
   parameter int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr
);
   initial assert (DEPTH >= 2) else $error("evr_ring_ptr: DEPTH must be at least 2");

   logic [PTR_W-1:0] nxt;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign nxt = ptr + 1'b1;
   end else begin : g_mod
      assign nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (adv) ptr <= nxt;
   end

   // R5
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ptr == LAST) |=> (ptr == '0));
   // R5
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(ptr));
endmodule

// File: rtl/event_ring_producer.sv
module event_ring_producer
   import evr_pkg::*;
#(
   parameter int RING_DEPTH = 8,
   parameter int CODE_W     = 8,
   parameter int ADDR_W     = 32,
   parameter int ELEM_BYTES = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_4000,
   localparam int PTR_W  = $clog2(RING_DEPTH),
   localparam int DESC_W = EVR_KIND_W + CODE_W,
   localparam int IDX_W  = $clog2(EVR_NSRC)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [EVR_NSRC-1:0]        src_valid,
   input  logic [EVR_NSRC*CODE_W-1:0] src_code,
   output logic [EVR_NSRC-1:0]        src_ready,
   input  logic                       host_wp_we,
   input  logic [PTR_W-1:0]           host_wp,
   output logic                       mw_valid,
   output logic [ADDR_W-1:0]          mw_addr,
   output logic [DESC_W-1:0]          mw_data,
   input  logic                       mw_ack,
   output logic                       irq
);
   initial assert (RING_DEPTH >= 2 && CODE_W >= 1 && ELEM_BYTES >= 1 && ADDR_W > PTR_W)
      else $error("event_ring_producer: bad parameter set");

   evr_phase_e          phase;
   logic [PTR_W-1:0]    rp;
   logic [PTR_W-1:0]    wp_q;
   logic [DESC_W-1:0]   desc_q;
   logic [EVR_NSRC-1:0] grant;
   logic [IDX_W-1:0]    pick;
   logic                ring_full;
   logic                open;
   logic                take;
   logic                done;
   evr_kind_e           kind;

   evr_prio_pick #(.N(EVR_NSRC)) u_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (src_valid),
      .grant (grant),
      .idx   (pick)
   );

   evr_ring_ptr #(.DEPTH(RING_DEPTH)) u_rp (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (done),
      .ptr   (rp)
   );

   // Swapped test: producer at rp, host frees by moving wp; equal means no room.
   assign ring_full = (rp == wp_q);
   assign open      = (phase == PH_IDLE) && !ring_full;
   assign src_ready = open ? grant : '0;
   assign take      = |(src_valid & src_ready);
   assign done      = (phase == PH_WRITE) && mw_ack;
   assign kind      = evr_kind_e'(pick);

   assign mw_valid = (phase == PH_WRITE);
   assign mw_data  = desc_q;
   assign mw_addr  = BASE_ADDR + (ADDR_W'(rp) * ADDR_W'(ELEM_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          wp_q <= PTR_W'(RING_DEPTH - 1);
      else if (host_wp_we) wp_q <= host_wp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         desc_q <= '0;
         irq    <= 1'b0;
      end else begin
         irq <= done;
         case (phase)
            PH_IDLE: if (take) begin
               desc_q <= {kind, src_code[pick*CODE_W +: CODE_W]};
               phase  <= PH_WRITE;
            end
            PH_WRITE: if (mw_ack) phase <= PH_IDLE;
            default:  phase <= PH_IDLE;
         endcase
      end
   end

   // R6
   no_take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ring_full |-> !(|(src_valid & src_ready)) ##1 !$rose(mw_valid));
   // R10
   busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mw_valid |-> (src_ready == '0));
   // R4
   hold_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_valid && !mw_ack) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));
   // R8
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
   // R8
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(mw_valid && mw_ack));
   // R8
   irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mw_valid && mw_ack) |=> irq);
endmodule

// File: tb/tb_event_ring_producer.sv
module tb_event_ring_producer;
   localparam int DEPTH = 8;
   localparam int CW    = 8;
   localparam int AW    = 32;
   localparam int EB    = 16;
   localparam logic [AW-1:0] BASE = 32'h0000_4000;
   localparam int PW    = $clog2(DEPTH);
   localparam int DW    = 2 + CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    src_valid = '0;
   logic [3*CW-1:0] src_code = '0;
   logic [2:0]    src_ready;
   logic          host_wp_we = 1'b0;
   logic [PW-1:0] host_wp = '0;
   logic          mw_valid;
   logic [AW-1:0] mw_addr;
   logic [DW-1:0] mw_data;
   logic          mw_ack = 1'b0;
   logic          irq;

   event_ring_producer #(
      .RING_DEPTH(DEPTH), .CODE_W(CW), .ADDR_W(AW), .ELEM_BYTES(EB), .BASE_ADDR(BASE)
   ) dut (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_code(src_code),
      .src_ready(src_ready), .host_wp_we(host_wp_we), .host_wp(host_wp),
      .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data),
      .mw_ack(mw_ack), .irq(irq)
   );

   always #4 clk = ~clk;

   typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } exp_t;
   exp_t exp_q[$];
   int checks = 0;
   int fails  = 0;
   int model_rp = 0;
   int ack_delay = 0;
   int wcnt = 0;
   bit done_flag = 0;

   task automatic chk(bit ok, string req, string what, longint act, longint expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic report();
      if (!done_flag) begin
         done_flag = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // R3 R5: expected descriptor at the modelled slot, kind = source index
   task automatic push_exp(int src, logic [CW-1:0] code);
      exp_t e;
      e.a = BASE + AW'(model_rp * EB);
      e.d = {2'(src), code};
      exp_q.push_back(e);
      model_rp = (model_rp + 1) % DEPTH;
   endtask

   // Memory responder and monitor: compares on the edge it acknowledges.
   always @(negedge clk) begin
      bit irq_due;
      exp_t e;
      irq_due = mw_ack;
      if (!rst_n) begin
         mw_ack <= 1'b0;
         wcnt   <= 0;
      end else begin
         if (irq_due) chk(irq == 1'b1, "R8", "irq after ack", irq, 1);
         else if (irq) chk(1'b0, "R8", "irq without ack", irq, 0);
         if (mw_valid && !mw_ack) begin
            if (wcnt >= ack_delay) begin
               mw_ack <= 1'b1;
               wcnt   <= 0;
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R6", "unexpected write addr", mw_addr, 0);
               end else begin
                  e = exp_q.pop_front();
                  chk(mw_addr == e.a, "R5", "slot address", mw_addr, e.a);
                  chk(mw_data == e.d, "R3", "descriptor", mw_data, e.d);
               end
            end else begin
               wcnt <= wcnt + 1;
            end
         end else begin
            mw_ack <= 1'b0;
         end
      end
   end

   task automatic send(int src, logic [CW-1:0] code);
      @(negedge clk);
      src_code[src*CW +: CW] = code;
      src_valid[src] = 1'b1;
      #1;
      while (!src_ready[src]) begin
         @(negedge clk);
         #1;
      end
      push_exp(src, code);
      @(negedge clk);
      src_valid[src] = 1'b0;
   endtask

   task automatic drain();
      @(negedge clk);
      while (exp_q.size() != 0 || mw_valid || mw_ack) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic set_wp(logic [PW-1:0] v);
      @(negedge clk);
      host_wp_we = 1'b1;
      host_wp = v;
      @(negedge clk);
      host_wp_we = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      chk(1'b0, "watchdog", "run timed out", 0, 1);
      report();
   end

   initial begin
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(mw_valid == 1'b0, "R1", "mw_valid in reset", mw_valid, 0);
      chk(irq == 1'b0, "R1", "irq in reset", irq, 0);
      chk(src_ready == 3'b000, "R1", "src_ready in reset", src_ready, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R3: first event at slot 0, each kind
      send(2, 8'h11);
      send(1, 8'h22);
      send(0, 8'h33);
      drain();

      // R10: request during a slow acknowledge is held off
      ack_delay = 4;
      send(2, 8'h44);
      #1;
      chk(mw_valid == 1'b1, "R10", "write outstanding", mw_valid, 1);
      src_code[1*CW +: CW] = 8'h55;
      src_valid[1] = 1'b1;
      #1;
      chk(src_ready == 3'b000, "R10", "ready while busy", src_ready, 0);
      @(negedge clk);
      #1;
      chk(src_ready == 3'b000, "R10", "ready while busy later", src_ready, 0);
      while (!src_ready[1]) begin
         @(negedge clk);
         #1;
      end
      push_exp(1, 8'h55);
      @(negedge clk);
      src_valid[1] = 1'b0;
      drain();
      ack_delay = 0;

      // rp = 5; give back room so the next events wrap past slot 7
      set_wp(3'd3);

      // R9: state change beats transfer completion
      @(negedge clk);
      src_code = {8'h66, 8'h00, 8'h77};
      src_valid = 3'b101;
      #1;
      chk(src_ready == 3'b001, "R9", "state over transfer", src_ready, 3'b001);
      push_exp(0, 8'h77);
      @(negedge clk);
      src_valid[0] = 1'b0;
      #1;
      while (!src_ready[2]) begin
         @(negedge clk);
         #1;
      end
      push_exp(2, 8'h66);
      @(negedge clk);
      src_valid[2] = 1'b0;
      drain();

      // R9: command completion beats transfer completion
      @(negedge clk);
      src_code = {8'h88, 8'h99, 8'h00};
      src_valid = 3'b110;
      #1;
      chk(src_ready == 3'b010, "R9", "command over transfer", src_ready, 3'b010);
      push_exp(1, 8'h99);
      @(negedge clk);
      src_valid[1] = 1'b0;
      #1;
      while (!src_ready[2]) begin
         @(negedge clk);
         #1;
      end
      push_exp(2, 8'h88);   // lands in slot 0 after the wrap (R5)
      @(negedge clk);
      src_valid[2] = 1'b0;
      drain();

      // rp = 1, wp = 3: exactly two more fit, then full (R7, R6)
      send(2, 8'hA1);
      send(2, 8'hA2);
      drain();
      @(negedge clk);
      src_code[2*CW +: CW] = 8'hA3;
      src_valid[2] = 1'b1;
      for (int i = 0; i < 5; i++) begin
         #1;
         chk(src_ready == 3'b000, "R6", "ready when full", src_ready, 0);
         chk(mw_valid == 1'b0, "R6", "write when full", mw_valid, 0);
         @(negedge clk);
      end
      src_valid[2] = 1'b0;

      // R7: host returns two slots (wp 3 -> 5)
      set_wp(3'd5);
      send(2, 8'hA3);
      send(0, 8'hA4);
      drain();
      @(negedge clk);
      src_valid[1] = 1'b1;
      #1;
      chk(src_ready == 3'b000, "R7", "full again after two", src_ready, 0);
      repeat (3) @(negedge clk);
      chk(mw_valid == 1'b0, "R7", "no extra write", mw_valid, 0);
      src_valid[1] = 1'b0;
      chk(exp_q.size() == 0, "R3", "all expected writes seen", exp_q.size(), 0);
      repeat (3) @(negedge clk);
      report();
   end
endmodule